// File: doc/BRIEF.md
# Shader Program Flow Sequencer

This block owns the program counter of a small vector shader core. It fetches 32-bit instruction words from a synchronous program memory and decodes the opcode in the top six bits. It resolves program flow for a stop instruction, a no-operation, a conditional subroutine call and a conditional if/else block. Both conditional instructions test one bit of a 16-bit boolean uniform register, which is loaded through a register-write port. Arithmetic instructions are recognised and stepped over without being executed.

There are no return or end-of-block instructions. The sequencer keeps a call stack and an if stack in hardware. Every entry stores an ending address. The entry is popped when the program counter reaches that address after any instruction, and the counter then takes the address stored with it. A start pulse begins a run at address 0. The run ends at a stop instruction, at an undefined opcode, or when a stack overflows. The cause of a halt is kept in sticky error flags until the next start.

Top module: `shader_flow_seq`

## Requirements
- R1: A start pulse sets the PC to 0, empties both stacks and clears done and all error flags. The next cycle shows busy=1, done=0 and imem_addr=0. After reset the block is idle with every output at 0.
- R2: Each instruction takes two cycles: a fetch cycle, then an execute cycle. imem_addr holds the instruction's address for both cycles, and memory data arrives one cycle after the address.
- R3: The opcode is bits [31:26]. The step class advances the PC by one: 0x00, 0x01, 0x02, 0x08, 0x0D, 0x0F, 0x12, 0x13, 0x21 (no-op), 0x2E, 0x2F and every value from 0x38 to 0x3F. Opcode 0x22 halts: two cycles after its fetch begins, done=1 and busy=0.
- R4: Any other opcode, including 0x28 and 0x29, halts the run and sets err_undef.
- R5: A write on the uniform port keeps only bits [15:0] of ureg_wdata. Bit 16 and above have no effect on any conditional test.
- R6: The call instruction (opcode 0x26) takes its fields as follows: uniform bit index in [25:22], target in [21:10], count in [7:0]. If the selected bit is set, it pushes ending address = target+count (12-bit wrap) together with return address = PC+1, and jumps to the target. If the bit is clear, it advances by one.
- R7: The if instruction (opcode 0x27) takes the same fields. If the selected bit is set, it pushes ending address = target and continuation address = target+count, then advances by one. If the bit is clear, it jumps to the target.
- R8: After every instruction, the next PC is first compared with the top if entry, which may be one pushed by that same instruction. On a match the PC takes the continuation address and the entry pops. The resulting PC is then compared with the top call entry. On a match the PC takes the return address and the entry pops.
- R9: A call push when 4 call entries are already in use sets err_call_ovf and halts, and no entry is pushed.
- R10: An if push when 8 if entries are already in use sets err_if_ovf and halts, and no entry is pushed.
- R11: The error flags and done stay set until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run at address 0 |
| imem_addr | output | 12 | Program memory read address |
| imem_rdata | input | 32 | Program memory data, one cycle after the address |
| ureg_we | input | 1 | Boolean uniform write enable |
| ureg_wdata | input | 32 | Boolean uniform write value (low 16 bits kept) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has halted |
| err_undef | output | 1 | Sticky: an undefined opcode was found |
| err_call_ovf | output | 1 | Sticky: call stack overflow |
| err_if_ovf | output | 1 | Sticky: if stack overflow |

## Verification
Count the cycles from the clock edge that samples start as edge S. The address of the k-th executed instruction is on imem_addr in the cycle after edge S+2k, and busy stays high in the execute cycle that follows it. For a run of N instructions, done and the error flags are due in the cycle after edge S+2N. The bench samples each of these at the falling edge of exactly those cycles. It compares them with a trace and an outcome from its own interpreter of the requirements. Directed programs cover the count-zero call, both arms of the if, a simultaneous if and call pop, the uniform masking, and both overflows. Random programs cover everything else.

// File: rtl/shader_flow_pkg.sv
package shader_flow_pkg;

    localparam int ADDR_W  = 12;
    localparam int CNT_W   = 8;
    localparam int SEL_W   = 4;
    localparam int UNIF_W  = 16;
    localparam int INSTR_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        CLS_STEP  = 3'd0,
        CLS_HALT  = 3'd1,
        CLS_CALL  = 3'd2,
        CLS_COND  = 3'd3,
        CLS_BAD   = 3'd4
    } op_class_e;

    localparam logic [5:0] OPC_HALT = 6'h22;
    localparam logic [5:0] OPC_CALL = 6'h26;
    localparam logic [5:0] OPC_COND = 6'h27;

    typedef struct packed {
        logic [ADDR_W-1:0] end_addr;
        logic [ADDR_W-1:0] alt_addr;
    } stk_entry_t;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic              done;
        logic              e_undef;
        logic              e_covf;
        logic              e_iovf;
        logic [UNIF_W-1:0] unif;
    } seq_t;

    function automatic op_class_e classify(input logic [5:0] op);
        op_class_e c;
        case (op)
            6'h00, 6'h01, 6'h02, 6'h08, 6'h0D, 6'h0F,
            6'h12, 6'h13, 6'h21, 6'h2E, 6'h2F,
            6'h38, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D,
            6'h3E, 6'h3F: c = CLS_STEP;
            OPC_HALT:     c = CLS_HALT;
            OPC_CALL:     c = CLS_CALL;
            OPC_COND:     c = CLS_COND;
            default:      c = CLS_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import shader_flow_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output op_class_e          cls,
    output logic [ADDR_W-1:0]  target,
    output logic [CNT_W-1:0]   count,
    output logic [SEL_W-1:0]   sel
);
    logic unused_pad;

    always_comb begin
        cls    = classify(instr[31:26]);
        sel    = instr[25:22];
        target = instr[21:10];
        count  = instr[7:0];
    end

    assign unused_pad = ^instr[9:8];

endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  ent_q [DEPTH];
    logic [CW-1:0] cnt_d, cnt_q;
    logic [IW-1:0] top_idx;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign top_idx = IW'(cnt_q - 1'b1);
    assign top     = empty ? '0 : ent_q[top_idx];

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (push && !full)
            cnt_d = cnt_q + 1'b1;
        else if (pop && !empty)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[i] <= '0;
            else if (!clear && push && !full && cnt_q == CW'(i))
                ent_q[i] <= wdata;
        end
    end

    // R9 / R10: occupancy never passes the depth
    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R8: a pop is requested only when an entry exists
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear) |-> !empty);

    // R9 / R10: a push is never requested on a full stack
    a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> !full);

endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
    import shader_flow_pkg::*;
#(
    parameter int CALL_DEPTH = 4,
    parameter int IF_DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic               ureg_we,
    input  logic [INSTR_W-1:0] ureg_wdata,
    output logic               busy,
    output logic               done,
    output logic               err_undef,
    output logic               err_call_ovf,
    output logic               err_if_ovf
);
    localparam int EW = $bits(stk_entry_t);

    seq_t s_d, s_q;

    op_class_e         dec_cls;
    logic [ADDR_W-1:0] dec_tgt;
    logic [CNT_W-1:0]  dec_cnt;
    logic [SEL_W-1:0]  dec_sel;

    logic       c_push, c_pop, c_full, c_empty;
    logic       i_push, i_pop, i_full, i_empty;
    stk_entry_t c_wdata, c_top, i_wdata, i_top;
    logic [EW-1:0] c_top_raw, i_top_raw;
    logic       stk_clear;
    logic       unused_hi;

    assign unused_hi = ^ureg_wdata[INSTR_W-1:UNIF_W];

    flow_decode u_dec (
        .instr  (imem_rdata),
        .cls    (dec_cls),
        .target (dec_tgt),
        .count  (dec_cnt),
        .sel    (dec_sel)
    );

    flow_stack #(.DEPTH(CALL_DEPTH), .W(EW)) u_call_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stk_clear),
        .push  (c_push && !c_pop),
        .pop   (c_pop && !c_push),
        .wdata (c_wdata),
        .top   (c_top_raw),
        .full  (c_full),
        .empty (c_empty)
    );

    flow_stack #(.DEPTH(IF_DEPTH), .W(EW)) u_if_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stk_clear),
        .push  (i_push && !i_pop),
        .pop   (i_pop && !i_push),
        .wdata (i_wdata),
        .top   (i_top_raw),
        .full  (i_full),
        .empty (i_empty)
    );

    assign c_top = stk_entry_t'(c_top_raw);
    assign i_top = stk_entry_t'(i_top_raw);

    always_comb begin
        logic [ADDR_W-1:0] nxt;
        logic              halt;
        logic              ubit;
        stk_entry_t        eff;

        s_d       = s_q;
        nxt       = s_q.pc + 1'b1;
        halt      = 1'b0;
        ubit      = s_q.unif[dec_sel];
        c_push    = 1'b0;
        c_pop     = 1'b0;
        i_push    = 1'b0;
        i_pop     = 1'b0;
        c_wdata   = '0;
        i_wdata   = '0;
        stk_clear = 1'b0;
        eff       = '0;

        if (ureg_we)
            s_d.unif = ureg_wdata[UNIF_W-1:0];

        if (start) begin
            s_d.state   = ST_FETCH;
            s_d.pc      = '0;
            s_d.done    = 1'b0;
            s_d.e_undef = 1'b0;
            s_d.e_covf  = 1'b0;
            s_d.e_iovf  = 1'b0;
            stk_clear   = 1'b1;
        end else begin
            case (s_q.state)
                ST_FETCH: s_d.state = ST_EXEC;
                ST_EXEC: begin
                    case (dec_cls)
                        CLS_STEP: ;
                        CLS_HALT: halt = 1'b1;
                        CLS_BAD: begin
                            halt        = 1'b1;
                            s_d.e_undef = 1'b1;
                        end
                        CLS_CALL: begin
                            if (ubit) begin
                                if (c_full) begin
                                    halt       = 1'b1;
                                    s_d.e_covf = 1'b1;
                                end else begin
                                    c_push           = 1'b1;
                                    c_wdata.end_addr = dec_tgt + ADDR_W'(dec_cnt);
                                    c_wdata.alt_addr = nxt;
                                    nxt              = dec_tgt;
                                end
                            end
                        end
                        CLS_COND: begin
                            if (ubit) begin
                                if (i_full) begin
                                    halt       = 1'b1;
                                    s_d.e_iovf = 1'b1;
                                end else begin
                                    i_push           = 1'b1;
                                    i_wdata.end_addr = dec_tgt;
                                    i_wdata.alt_addr = dec_tgt + ADDR_W'(dec_cnt);
                                end
                            end else begin
                                nxt = dec_tgt;
                            end
                        end
                        default: begin
                            halt        = 1'b1;
                            s_d.e_undef = 1'b1;
                        end
                    endcase

                    if (halt) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                        c_push    = 1'b0;
                        i_push    = 1'b0;
                    end else begin
                        eff = i_push ? i_wdata : i_top;
                        if ((i_push || !i_empty) && nxt == eff.end_addr) begin
                            nxt   = eff.alt_addr;
                            i_pop = 1'b1;
                        end
                        eff = c_push ? c_wdata : c_top;
                        if ((c_push || !c_empty) && nxt == eff.end_addr) begin
                            nxt   = eff.alt_addr;
                            c_pop = 1'b1;
                        end
                        s_d.pc    = nxt;
                        s_d.state = ST_FETCH;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign imem_addr    = s_q.pc;
    assign busy         = (s_q.state != ST_IDLE);
    assign done         = s_q.done;
    assign err_undef    = s_q.e_undef;
    assign err_call_ovf = s_q.e_covf;
    assign err_if_ovf   = s_q.e_iovf;

    // R1: a start leaves a clean running state fetching address 0
    a_r1_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && imem_addr == '0 &&
                   !err_undef && !err_call_ovf && !err_if_ovf));

    // R2: the fetch address is held through the execute cycle
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EXEC) |-> $stable(imem_addr));

    // R3: a halted run is never busy
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: an undefined opcode in execute halts with the error flag
    a_r4_undef_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EXEC && dec_cls == CLS_BAD && !start)
        |=> (err_undef && done && !busy));

    // R11: error flags stay set until a start
    a_r11_sticky_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (err_undef && !start) |=> err_undef);
    a_r11_sticky_covf: assert property (@(posedge clk) disable iff (!rst_n)
        (err_call_ovf && !start) |=> err_call_ovf);
    a_r11_sticky_iovf: assert property (@(posedge clk) disable iff (!rst_n)
        (err_if_ovf && !start) |=> err_if_ovf);

    // R9: a taken call on a full call stack reports overflow
    a_r9_call_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EXEC && dec_cls == CLS_CALL && s_q.unif[dec_sel]
         && c_full && !start) |=> (err_call_ovf && done));

    // R10: a taken if on a full if stack reports overflow
    a_r10_if_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EXEC && dec_cls == CLS_COND && s_q.unif[dec_sel]
         && i_full && !start) |=> (err_if_ovf && done));

endmodule

// File: tb/shader_flow_seq_test.sv
module shader_flow_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXSTEP    = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        ureg_we = 1'b0;
    logic [31:0] ureg_wdata = '0;
    logic        busy, done, err_undef, err_call_ovf, err_if_ovf;

    logic [31:0] mem [0:255];
    logic [15:0] unif_m;
    logic [11:0] trace [0:MAXSTEP-1];
    int          n_m;
    int          res_m;
    int          checks = 0;
    int          errors = 0;

    shader_flow_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .ureg_we(ureg_we), .ureg_wdata(ureg_wdata),
        .busy(busy), .done(done), .err_undef(err_undef),
        .err_call_ovf(err_call_ovf), .err_if_ovf(err_if_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) imem_rdata <= mem[imem_addr[7:0]];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_step(input logic [5:0] op);
        case (op)
            6'h00, 6'h01, 6'h02, 6'h08, 6'h0D, 6'h0F, 6'h12, 6'h13,
            6'h21, 6'h2E, 6'h2F: return 1'b1;
            default: return (op >= 6'h38);
        endcase
    endfunction

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [3:0] b,
                                        input logic [11:0] t, input logic [7:0] c);
        return {op, b, t, 2'b00, c};
    endfunction

    // interpreter of the requirements: res 0 end, 1 undef, 2 call ovf, 3 if ovf, 4 no halt
    task automatic model_run();
        logic [11:0] pc, nx, tg;
        logic [11:0] ce [0:3], cr [0:3], ie [0:7], ic [0:7];
        int cc, icn;
        logic [31:0] w;
        pc = '0; cc = 0; icn = 0; n_m = 0; res_m = 4;
        while (n_m < MAXSTEP) begin
            trace[n_m] = pc;
            n_m++;
            w  = mem[pc[7:0]];
            nx = pc + 12'd1;
            tg = w[21:10];
            if (w[31:26] == 6'h22) begin res_m = 0; return; end
            else if (w[31:26] == 6'h26) begin
                if (unif_m[w[25:22]]) begin
                    if (cc == 4) begin res_m = 2; return; end
                    ce[cc] = tg + {4'd0, w[7:0]}; cr[cc] = nx; cc++;
                    nx = tg;
                end
            end else if (w[31:26] == 6'h27) begin
                if (unif_m[w[25:22]]) begin
                    if (icn == 8) begin res_m = 3; return; end
                    ie[icn] = tg; ic[icn] = tg + {4'd0, w[7:0]}; icn++;
                end else nx = tg;
            end else if (!is_step(w[31:26])) begin res_m = 1; return; end
            if (icn > 0 && nx == ie[icn-1]) begin nx = ic[icn-1]; icn--; end
            if (cc > 0 && nx == ce[cc-1]) begin nx = cr[cc-1]; cc--; end
            pc = nx;
        end
    endtask

    task automatic set_unif(input logic [31:0] v);
        @(negedge clk); ureg_we = 1'b1; ureg_wdata = v;
        @(negedge clk); ureg_we = 1'b0;
        unif_m = v[15:0];
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = enc(6'h22, 4'd0, 12'd0, 8'd0);
    endtask

    task automatic run_and_check(input string tag);
        int mism;
        model_run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R1 busy after start"}, int'(busy), 1);
        check({tag, " R1 flags cleared by start"},
              int'({done, err_undef, err_call_ovf, err_if_ovf}), 0);
        mism = 0;
        for (int k = 0; k < n_m; k++) begin
            if (imem_addr !== trace[k]) mism++;
            @(negedge clk);
            if (busy !== 1'b1 || imem_addr !== trace[k]) mism++;
            @(negedge clk);
        end
        check({tag, " R2 R6 R7 R8 fetch trace mismatches"}, mism, 0);
        check({tag, " R3 done at 2N cycles"}, int'({done, busy}), 2);
        check({tag, " R4 R9 R10 error flags"},
              int'({err_undef, err_call_ovf, err_if_ovf}),
              (res_m == 1) ? 4 : (res_m == 2) ? 2 : (res_m == 3) ? 1 : 0);
        repeat (3) @(negedge clk);
        check({tag, " R11 flags hold while idle"},
              int'({done, err_undef, err_call_ovf, err_if_ovf}),
              {1'b1, res_m == 1, res_m == 2, res_m == 3});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog actual hung expected halt");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] steps [0:10];
        steps = '{6'h00, 6'h01, 6'h02, 6'h08, 6'h0D, 6'h0F, 6'h12, 6'h13, 6'h21, 6'h2E, 6'h2F};
        void'($urandom(32'h0005eed1));
        unif_m = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset idle", int'({busy, done, err_undef, err_call_ovf, err_if_ovf}), 0);
        check("R1 reset address", int'(imem_addr), 0);

        // R3 step class and halt
        clear_mem();
        mem[0] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        mem[1] = enc(6'h3A, 4'd5, 12'd9, 8'd3);
        mem[2] = enc(6'h0F, 4'd0, 12'd0, 8'd0);
        mem[3] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        run_and_check("R3 straight");

        // R5 masking, R6 call taken and skipped
        clear_mem();
        mem[0] = enc(6'h26, 4'd0, 12'd4, 8'd2);
        mem[1] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        mem[4] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        mem[5] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        set_unif(32'h0001_0000);
        run_and_check("R5 high bits ignored");
        check("R5 call skipped length", n_m, 2);
        set_unif(32'h0000_0001);
        run_and_check("R6 call taken");
        check("R6 call taken length", n_m, 4);

        // R6 count zero call pops at once
        clear_mem();
        mem[0] = enc(6'h26, 4'd2, 12'd5, 8'd0);
        mem[1] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        set_unif(32'h0000_0004);
        run_and_check("R6 count zero");

        // R7 both arms
        clear_mem();
        mem[0] = enc(6'h27, 4'd3, 12'd3, 8'd2);
        for (int i = 1; i < 5; i++) mem[i] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        mem[5] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        set_unif(32'h0000_0000);
        run_and_check("R7 else arm");
        set_unif(32'h0000_0008);
        run_and_check("R7 then arm");

        // R8 if pop then call pop on one instruction
        clear_mem();
        mem[0] = enc(6'h26, 4'd0, 12'd4, 8'd3);
        mem[1] = enc(6'h22, 4'd0, 12'd0, 8'd0);
        mem[4] = enc(6'h27, 4'd1, 12'd6, 8'd1);
        mem[5] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        set_unif(32'h0000_0003);
        run_and_check("R8 double pop");
        check("R8 double pop length", n_m, 4);

        // R4 undefined opcode
        clear_mem();
        mem[0] = enc(6'h21, 4'd0, 12'd0, 8'd0);
        mem[1] = enc(6'h29, 4'd0, 12'd0, 8'd0);
        run_and_check("R4 undefined");

        // R9 call overflow
        clear_mem();
        for (int i = 0; i < 5; i++) mem[i] = enc(6'h26, 4'd0, 12'(i + 1), 8'd20);
        set_unif(32'h0000_0001);
        run_and_check("R9 call overflow");
        check("R9 model outcome", res_m, 2);

        // R10 if overflow
        clear_mem();
        for (int i = 0; i < 9; i++) mem[i] = enc(6'h27, 4'd0, 12'd40, 8'd1);
        run_and_check("R10 if overflow");
        check("R10 model outcome", res_m, 3);

        // R11 restart after error is clean
        clear_mem();
        mem[0] = enc(6'h13, 4'd0, 12'd0, 8'd0);
        run_and_check("R11 restart clean");

        // random programs
        for (int p = 0; p < 14; p++) begin
            int tries = 0;
            do begin
                clear_mem();
                for (int a = 0; a < 64; a++) begin
                    int r;
                    r = $urandom % 10;
                    if (r < 4)      mem[a] = enc(steps[$urandom % 11], 4'($urandom), 12'($urandom), 8'($urandom));
                    else if (r < 6) mem[a] = enc(6'h26, 4'($urandom), 12'(a + 1 + $urandom % 8), 8'($urandom % 6));
                    else if (r < 8) mem[a] = enc(6'h27, 4'($urandom), 12'(a + 1 + $urandom % 8), 8'($urandom % 6));
                    else if (r < 9) mem[a] = (($urandom % 4) == 0) ? enc(6'h22, 4'd0, 12'd0, 8'd0)
                                                                    : enc(6'h21, 4'd0, 12'd0, 8'd0);
                    else            mem[a] = enc(6'(6'h38 + $urandom % 8), 4'($urandom), 12'($urandom), 8'($urandom));
                end
                unif_m = 16'($urandom);
                model_run();
                tries++;
            end while (res_m == 4 && tries < 20);
            set_unif({16'($urandom), unif_m});
            run_and_check($sformatf("R6 R7 R8 random %0d", p));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule